// File: doc/BRIEF.md
# Fixed-to-Float Normaliser

This block turns a wide two's-complement fixed-point word into a packed IEEE-style binary floating-point word. The bit weights of the fixed-point word are fixed at elaboration by two parameters: the weight of its top bit and the weight of its bottom bit. The exponent and fraction widths of the float result are parameters as well. It is meant to sit behind a wide fixed-point accumulator, so that the exact running sum can be read back as an ordinary float.

The conversion is a short pipeline. The first stage splits off the sign and forms the magnitude. The second stage counts leading zeros, normalises with a shifter and builds the biased exponent. It then rounds to nearest-even and handles the zero, subnormal and overflow cases. There is no back-pressure. Every input marked valid produces one result two clock edges later.

Top module: `fix2flt`

## Requirements
- R1: Input bit i of `in_fix` has weight 2^(LSB_WT+i), so W = MSB_WT-LSB_WT+1 bits. The word is two's complement, and the most negative code converts to its full magnitude (for example -2^MSB_WT).
- R2: `out_valid` is high exactly two rising edges after a cycle with `in_valid` high, and low otherwise. While `out_valid` is low, `out_float` keeps its last value.
- R3: Bit EXP_W+FRAC_W of `out_float` equals bit W-1 of the input that produced it. A negative input is negated to obtain its magnitude.
- R4: For a normal result with its leading one at bit weight e, the exponent field (bits EXP_W+FRAC_W-1 down to FRAC_W) is e + BIAS, with BIAS = 2^(EXP_W-1)-1. The fraction field (bits FRAC_W-1 down to 0) holds the bits below the leading one.
- R5: Bits below the fraction are rounded to nearest. A tie (guard bit set, no lower bit set) goes to the even fraction.
- R6: A rounding carry out of the fraction increments the exponent field and clears the fraction.
- R7: An all-zero input gives all-zero output (positive zero).
- R8: A magnitude whose rounded exponent field would reach 2^EXP_W-1 gives infinity of the input's sign: exponent all ones, fraction zero.
- R9: A magnitude below 2^(1-BIAS) gives exponent field 0 and a subnormal fraction scaled by 2^(1-BIAS-FRAC_W), rounded as in R5. It may round to zero or up to the smallest normal.
- R10: During and right after reset, `out_valid` is 0 and `out_float` is 0.
- R11: A valid output never has the exponent all ones with a nonzero fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_fix` as a value to convert |
| in_fix | input | MSB_WT-LSB_WT+1 | Two's-complement fixed-point input |
| out_valid | output | 1 | Marks `out_float` as a new result |
| out_float | output | EXP_W+FRAC_W+1 | Sign, exponent field, fraction field |

## Verification
Rounding and range limiting can both act on the same value in one cycle. A round-up carry can push the largest finite exponent into infinity, or lift a subnormal into the smallest normal. Directed inputs place exact ties and near-ties at the top of the finite range and at the subnormal/normal border. Each result is judged against an independent bench model that rounds an integer mantissa and classifies it afterwards. Random magnitudes across the full input range then mix these cases with ordinary normal results in a back-to-back stream.

// File: rtl/fix2flt.sv
module fix2flt #(
  parameter int MSB_WT = 20,
  parameter int LSB_WT = -30,
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [MSB_WT-LSB_WT:0]            in_fix,
  output logic                              out_valid,
  output logic [EXP_W+FRAC_W:0]             out_float
);
  localparam int W     = MSB_WT - LSB_WT + 1;
  localparam int LZW   = $clog2(W + 1);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int EMIN  = 1 - BIAS;
  localparam int EMAXF = (1 << EXP_W) - 1;
  localparam int SUBLIM = MSB_WT - EMIN;
  localparam int SHMAX = (SUBLIM < 0) ? 0 : ((SUBLIM > W) ? W : SUBLIM);
  localparam int XW    = W + FRAC_W + 2;
  localparam int FW    = EXP_W + FRAC_W + 1;

  logic           s1_v, s1_sign;
  logic [W-1:0]   s1_mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_sign <= 1'b0;
      s1_mag  <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_sign <= in_fix[W-1];
        s1_mag  <= in_fix[W-1] ? ({W{1'b0}} - in_fix) : in_fix;
      end
    end
  end

  logic [LZW-1:0] lz;
  always_comb begin
    lz = LZW'(W);
    for (int i = 0; i < W; i++)
      if (s1_mag[i]) lz = LZW'(W - 1 - i);
  end

  logic [LZW-1:0]         sh;
  logic [XW-1:0]          xs;
  logic                   hid, grd, stk, inc, big;
  logic [FRAC_W-1:0]      frac;
  logic signed [31:0]     eb;
  logic [EXP_W-1:0]       efld;
  logic [EXP_W+FRAC_W-1:0] sum;
  logic [FW-1:0]          res;

  assign sh   = (int'(lz) < SHMAX) ? lz : LZW'(SHMAX);
  assign xs   = {s1_mag, {(FRAC_W+2){1'b0}}} << sh;
  assign hid  = xs[XW-1];
  assign frac = xs[XW-2 -: FRAC_W];
  assign grd  = xs[W];
  assign stk  = |xs[W-1:0];
  assign eb   = MSB_WT - int'(lz) + BIAS;
  assign big  = hid && (eb >= EMAXF);
  assign efld = hid ? eb[EXP_W-1:0] : '0;
  assign inc  = grd & (stk | frac[0]);
  assign sum  = {efld, frac} + {{(EXP_W+FRAC_W-1){1'b0}}, inc};
  assign res  = big ? {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}} : {s1_sign, sum};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_float <= '0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) out_float <= res;
    end
  end
endmodule

// File: rtl/fix2flt_chk.sv
module fix2flt_chk #(
  parameter int W      = 51,
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [W-1:0]          in_fix,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] out_float
);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_float));
  assert_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_fix[W-1]) |-> ##2 out_float[EXP_W+FRAC_W]);
  assert_pos_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_fix == '0) |-> ##2 (out_float == '0));
  assert_no_nan_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !((&out_float[EXP_W+FRAC_W-1:FRAC_W]) && (|out_float[FRAC_W-1:0])));
endmodule

bind fix2flt fix2flt_chk #(.W(W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fix(in_fix),
  .out_valid(out_valid), .out_float(out_float));

// File: tb/fix2flt_test.sv
module fix2flt_test;
  localparam int MSB = 20, LSB = -30, EW = 5, FB = 10;
  localparam int W = MSB - LSB + 1, BIAS = 15, EMIN = -14;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [W-1:0] in_fix = '0;
  logic out_valid;
  logic [15:0] out_float;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  fix2flt #(.MSB_WT(MSB), .LSB_WT(LSB), .EXP_W(EW), .FRAC_W(FB)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fix(in_fix),
    .out_valid(out_valid), .out_float(out_float));

  function automatic logic [15:0] ref_cvt(input logic [W-1:0] x);
    logic s; logic [63:0] mag, m; int p, e, q, k, ex; logic g, st;
    s = x[W-1];
    mag = {13'b0, x};
    if (s) mag = (64'd1 << W) - mag;
    if (mag == 0) return 16'h0000;
    p = 63;
    while (!mag[p]) p--;
    e = p + LSB;
    q = ((e > EMIN) ? e : EMIN) - FB;
    k = q - LSB;
    if (k <= 0) begin m = mag << (-k); g = 0; st = 0; end
    else begin
      m = mag >> k; g = mag[k-1];
      st = (k > 1) ? |(mag & ((64'd1 << (k-1)) - 1)) : 1'b0;
    end
    if (g && (st || m[0])) m++;
    if (m >= (64'd1 << (FB+1))) begin m = m >> 1; q++; end
    if (m < (64'd1 << FB)) return {s, 5'd0, m[9:0]};
    ex = q + FB + BIAS;
    if (ex >= 31) return {s, 5'h1f, 10'd0};
    return {s, ex[4:0], m[9:0]};
  endfunction

  function automatic string tag_of(input logic [W-1:0] x, input logic [15:0] f);
    if (x == '0) return "R7";
    if (f[14:10] == 5'h1f) return "R8";
    if (f[14:10] == 5'h00) return "R9";
    return "R4/R5";
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic v1 = 0, v2 = 0;
  logic [W-1:0] x1 = '0, x2 = '0;
  logic [15:0] last = 16'h0;

  task automatic step(input logic v, input logic [W-1:0] x);
    @(negedge clk);
    check("R2 valid", {15'b0, out_valid}, {15'b0, v2});
    if (v2) begin
      check(tag_of(x2, ref_cvt(x2)), out_float, ref_cvt(x2));
      check("R3 sign", {15'b0, out_float[15]}, {15'b0, x2[W-1]});
      last = out_float;
    end else check("R2 hold", out_float, last);
    v2 = v1; x2 = x1; v1 = v; x1 = x;
    in_valid = v; in_fix = x;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] dir [16];
    void'($urandom(32'd1234));
    dir[0]  = '0;                          // R7
    dir[1]  = W'(1) << 30;                 // R1: 1.0 -> 3c00
    dir[2]  = -(W'(1) << 30);              // R3: -1.0
    dir[3]  = W'(65504) << 30;             // R4 largest finite
    dir[4]  = W'(65520) << 30;             // R8 tie rounds into infinity
    dir[5]  = W'(1) << (W-1);              // R1 most negative -> -inf
    dir[6]  = W'(4095) << 29;              // R6 2047.5 ties to 2048
    dir[7]  = W'(2049) << 30;              // R5 tie to even 2048
    dir[8]  = W'(2051) << 30;              // R5 tie to even 2052
    dir[9]  = W'(1) << 16;                 // R4 smallest normal
    dir[10] = W'(1) << 5;                  // R9 tie at half min subnormal -> 0
    dir[11] = (W'(1) << 5) | W'(1);        // R9 -> min subnormal
    dir[12] = W'(1);                       // R9 underflow to zero
    dir[13] = '1;                          // R9 -2^-30 -> -0
    dir[14] = (W'(1) << 16) - W'(1);       // R9/R6 rounds up to smallest normal
    dir[15] = {1'b0, {(W-1){1'b1}}};       // R8 max positive
    repeat (3) @(negedge clk);
    check("R10 valid", {15'b0, out_valid}, 16'h0);
    check("R10 data", out_float, 16'h0);
    rst_n = 1;
    for (int i = 0; i < 16; i++) step(1'b1, dir[i]);
    step(1'b0, '0);
    step(1'b0, '0);
    for (int i = 0; i < 16; i++) begin step(1'b1, dir[i]); step(1'b0, '0); end
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] r;
      r = {$urandom, $urandom} >> ($urandom % W);
      if ($urandom % 2) r = -r;
      step(($urandom % 5) != 0, r);
    end
    step(1'b0, '0);
    step(1'b0, '0);
    step(1'b0, '0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule